// File: doc/BRIEF.md
# Interval Timer with Compare Output

This block is a single count register that runs as a one-shot or a periodic interval timer, counting either down from a load value or up from zero. It drives one compare output pin. A 3-bit action code chooses whether the pin is forced high or low when the timer starts and what happens to it at each timeout. It also produces a timeout trigger pulse for the next timer in a chain, a maskable timeout interrupt pulse, and a match interrupt pulse that fires when the count equals a programmable match value.

Configuration arrives as plain input levels plus two write strobes, one for the load value and one for the match value. Each strobe either takes effect on the next clock or is held pending until the next timeout, depending on a per-value defer bit. A pending value is also applied when the timer starts. With wait-on-trigger set, the timer starts in a held state and only begins counting after a pulse arrives on the chain input. The timer starts on a rising edge of `enable_i` and stops as soon as `enable_i` is low.

Top module: `cmp_timer`

## Requirements
- R1: `mode_i` = 1 is one-shot: at timeout the timer stops and the count holds its final value until the next rising edge of `enable_i`. `mode_i` = 2 is periodic: the timer reloads and keeps running. With `mode_i` = 0 (or 3) the timer never starts and the count does not move. While `enable_i` is low the count holds.
- R2: Counting down, the count takes the load value on the start edge, decrements once per clock, and times out on the clock after it shows 0, which makes the period load+1 clocks. Counting up (`count_up_i` = 1), the count starts at 0 and times out on the clock after it equals the load value. A periodic reload returns to the load value when counting down and to 0 when counting up.
- R3: On the start edge the compare pin is set for action codes 4 and 6, cleared for codes 5 and 7, and left unchanged for codes 0 to 3.
- R4: At each timeout the compare pin toggles for codes 1, 4 and 5, clears for codes 2 and 6, sets for codes 3 and 7, and does not change for code 0.
- R5: With `load_defer_i` = 0, a load write while running down replaces the count on the next clock. With `load_defer_i` = 1, the new value is used first at the next timeout reload. When counting up, `load_defer_i` has no effect and a write takes effect on the next clock.
- R6: With `match_defer_i` = 1, a match write is held pending and takes effect at the next timeout. With `match_defer_i` = 0, it takes effect on the next clock.
- R7: A load or match value written with its defer bit set while the timer is stopped is applied when the timer starts.
- R8: With `wait_trig_i` set at start, the count holds its start value until `chain_trig_i` is high on a clock edge. Counting begins on the following edge.
- R9: `match_irq_o` pulses for one clock, on the edge after the running count equals the match value, only when `match_irq_en_i` = 1.
- R10: `tmo_trig_o` pulses for one clock on every timeout. `tmo_irq_o` pulses together with it unless `tmo_irq_mask_i` = 1, which suppresses only the interrupt.
- R11: After reset the count is 0, the compare pin is low and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; a rising edge starts the timer |
| mode_i | input | 2 | 1 one-shot, 2 periodic, others do not count |
| count_up_i | input | 1 | 1 counts up from 0, 0 counts down from load |
| cmp_act_i | input | 3 | Compare pin action code |
| load_val_i | input | 32 | Load value written by `load_wr_i` |
| load_wr_i | input | 1 | Load value write strobe |
| load_defer_i | input | 1 | Defer a load write to the next timeout |
| match_val_i | input | 32 | Match value written by `match_wr_i` |
| match_wr_i | input | 1 | Match value write strobe |
| match_defer_i | input | 1 | Defer a match write to the next timeout |
| wait_trig_i | input | 1 | Hold after start until a chain trigger arrives |
| chain_trig_i | input | 1 | Trigger pulse from the previous timer |
| tmo_irq_mask_i | input | 1 | Suppress the timeout interrupt |
| match_irq_en_i | input | 1 | Enable the match interrupt |
| count_o | output | 32 | Current count |
| cmp_o | output | 1 | Compare output pin |
| tmo_irq_o | output | 1 | Timeout interrupt pulse |
| match_irq_o | output | 1 | Match interrupt pulse |
| tmo_trig_o | output | 1 | Timeout trigger pulse to the next timer |

## Verification
The properties assume that configuration inputs change only between clock edges and that the load value is at least 1, so a timeout never falls on two edges in a row. The hold-while-waiting property also assumes that no load write arrives while the timer is held. The bench drives every input on the falling clock edge. It writes load and match values either while the timer is stopped or on cycles away from a timeout, and it uses loads of 2 or more. The chain trigger is pulsed for exactly one clock, and only while the timer is held.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_NONE     = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_PERIODIC = 2'd2,
        MODE_OTHER    = 2'd3
    } tmr_mode_e;

    // Pin action: value applied at start / behaviour at timeout
    typedef enum logic [2:0] {
        ACT_OFF     = 3'd0,
        ACT_TGL     = 3'd1,
        ACT_CLR     = 3'd2,
        ACT_SET     = 3'd3,
        ACT_SET_TGL = 3'd4,
        ACT_CLR_TGL = 3'd5,
        ACT_SET_CLR = 3'd6,
        ACT_CLR_SET = 3'd7
    } cmp_act_e;

endpackage

// File: rtl/tmr_shadow.sv
// Active value plus a pending copy that waits for an apply event.
module tmr_shadow #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         defer_i,
    input  logic         apply_i,
    output logic [W-1:0] act_o,
    output logic [W-1:0] nxt_o
);

    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] pend;
        logic         pend_vld;
    } shadow_t;

    shadow_t d, q;

    always_comb begin
        d = q;
        if (apply_i && q.pend_vld) begin
            d.act      = q.pend;
            d.pend_vld = 1'b0;
        end
        if (wr_i) begin
            if (defer_i) begin
                d.pend     = wdata_i;
                d.pend_vld = 1'b1;
            end else begin
                d.act      = wdata_i;
                d.pend_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_o = q.act;
    assign nxt_o = d.act;

endmodule

// File: rtl/tmr_cmp_out.sv
// Compare pin: forced on start, updated on timeout per action code.
module tmr_cmp_out
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tmo_i,
    input  logic [2:0] act_i,
    output logic       cmp_o
);

    logic     pin_d, pin_q;
    cmp_act_e act;

    assign act = cmp_act_e'(act_i);

    always_comb begin
        pin_d = pin_q;
        if (start_i) begin
            unique case (act)
                ACT_SET_TGL, ACT_SET_CLR: pin_d = 1'b1;
                ACT_CLR_TGL, ACT_CLR_SET: pin_d = 1'b0;
                default:                  pin_d = pin_q;
            endcase
        end else if (tmo_i) begin
            unique case (act)
                ACT_TGL, ACT_SET_TGL, ACT_CLR_TGL: pin_d = ~pin_q;
                ACT_CLR, ACT_SET_CLR:              pin_d = 1'b0;
                ACT_SET, ACT_CLR_SET:              pin_d = 1'b1;
                default:                           pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign cmp_o = pin_q;

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       mode_i,
    input  logic             count_up_i,
    input  logic [2:0]       cmp_act_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             load_wr_i,
    input  logic             load_defer_i,
    input  logic [CNT_W-1:0] match_val_i,
    input  logic             match_wr_i,
    input  logic             match_defer_i,
    input  logic             wait_trig_i,
    input  logic             chain_trig_i,
    input  logic             tmo_irq_mask_i,
    input  logic             match_irq_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_o,
    output logic             tmo_irq_o,
    output logic             match_irq_o,
    output logic             tmo_trig_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             wait_trig;
        logic             en_prev;
        logic             tmo_trig;
        logic             tmo_irq;
        logic             match_irq;
    } state_t;

    state_t d, q;

    tmr_mode_e        mode;
    logic             mode_ok, oneshot;
    logic             start, counting, tmo_hit, match_hit;
    logic             load_defer_eff, load_now, apply;
    logic [CNT_W-1:0] load_act, load_nxt, match_act, match_nxt;
    logic             running, waiting;

    assign mode    = tmr_mode_e'(mode_i);
    assign mode_ok = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
    assign oneshot = (mode == MODE_ONESHOT);

    assign start    = enable_i && !q.en_prev && mode_ok;
    assign counting = enable_i && q.run && !q.wait_trig && mode_ok;
    assign tmo_hit  = counting &&
                      (count_up_i ? (q.count == load_act) : (q.count == '0));
    assign match_hit = counting && (q.count == match_act);
    assign apply     = start || tmo_hit;

    // Deferral of the load value only matters when counting down
    assign load_defer_eff = load_defer_i && !count_up_i;
    assign load_now       = load_wr_i && !load_defer_eff && !count_up_i;

    tmr_shadow #(.W(CNT_W)) u_load_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (load_wr_i),
        .wdata_i (load_val_i),
        .defer_i (load_defer_eff),
        .apply_i (apply),
        .act_o   (load_act),
        .nxt_o   (load_nxt)
    );

    tmr_shadow #(.W(CNT_W)) u_match_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (match_wr_i),
        .wdata_i (match_val_i),
        .defer_i (match_defer_i),
        .apply_i (apply),
        .act_o   (match_act),
        .nxt_o   (match_nxt)
    );

    tmr_cmp_out u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .tmo_i   (tmo_hit),
        .act_i   (cmp_act_i),
        .cmp_o   (cmp_o)
    );

    always_comb begin
        d           = q;
        d.en_prev   = enable_i;
        d.tmo_trig  = tmo_hit;
        d.tmo_irq   = tmo_hit && !tmo_irq_mask_i;
        d.match_irq = match_hit && match_irq_en_i;

        if (!enable_i) begin
            d.run       = 1'b0;
            d.wait_trig = 1'b0;
        end else if (start) begin
            d.run       = 1'b1;
            d.wait_trig = wait_trig_i;
            d.count     = count_up_i ? '0 : load_nxt;
        end else if (q.run) begin
            if (tmo_hit) begin
                if (oneshot) d.run   = 1'b0;
                else         d.count = count_up_i ? '0 : load_nxt;
            end else if (load_now) begin
                d.count = load_val_i;
            end else if (counting) begin
                d.count = count_up_i ? q.count + ONE : q.count - ONE;
            end
            if (q.wait_trig && chain_trig_i) d.wait_trig = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count_o     = q.count;
    assign tmo_irq_o   = q.tmo_irq;
    assign match_irq_o = q.match_irq;
    assign tmo_trig_o  = q.tmo_trig;
    assign running     = q.run;
    assign waiting     = q.wait_trig;

    logic unused_ok;
    assign unused_ok = ^match_nxt;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic [1:0]       mode_i,
    input logic [2:0]       cmp_act_i,
    input logic             load_wr_i,
    input logic             chain_trig_i,
    input logic             tmo_irq_mask_i,
    input logic             match_irq_en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             cmp_o,
    input logic             tmo_irq_o,
    input logic             match_irq_o,
    input logic             tmo_trig_o,
    input logic             running,
    input logic             waiting
);

    assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> $stable(count_o));

    assert_oneshot_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_trig_o && $past(mode_i) == 2'd1) |-> !running);

    assert_act_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act_i == 3'd0) |=> $stable(cmp_o));

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && enable_i && !chain_trig_i && !load_wr_i) |=> $stable(count_o));

    assert_wait_no_tmo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |=> !tmo_trig_o);

    assert_match_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq_o |-> $past(match_irq_en_i));

    assert_irq_with_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq_o |-> tmo_trig_o);

    assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq_o |-> !$past(tmo_irq_mask_i));

endmodule

bind cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .mode_i         (mode_i),
    .cmp_act_i      (cmp_act_i),
    .load_wr_i      (load_wr_i),
    .chain_trig_i   (chain_trig_i),
    .tmo_irq_mask_i (tmo_irq_mask_i),
    .match_irq_en_i (match_irq_en_i),
    .count_o        (count_o),
    .cmp_o          (cmp_o),
    .tmo_irq_o      (tmo_irq_o),
    .match_irq_o    (match_irq_o),
    .tmo_trig_o     (tmo_trig_o),
    .running        (running),
    .waiting        (waiting)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;

    localparam int SEL_CNT = 0, SEL_CMP = 1, SEL_TIRQ = 2, SEL_MIRQ = 3, SEL_TRIG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 0, count_up_i = 0, load_wr_i = 0, load_defer_i = 0;
    logic        match_wr_i = 0, match_defer_i = 0, wait_trig_i = 0, chain_trig_i = 0;
    logic        tmo_irq_mask_i = 0, match_irq_en_i = 0;
    logic [1:0]  mode_i = 0;
    logic [2:0]  cmp_act_i = 0;
    logic [31:0] load_val_i = 0, match_val_i = 0;
    logic [31:0] count_o;
    logic        cmp_o, tmo_irq_o, match_irq_o, tmo_trig_o;

    always #2 clk = ~clk;

    cmp_timer i_cmp_timer (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
        .count_up_i(count_up_i), .cmp_act_i(cmp_act_i), .load_val_i(load_val_i),
        .load_wr_i(load_wr_i), .load_defer_i(load_defer_i), .match_val_i(match_val_i),
        .match_wr_i(match_wr_i), .match_defer_i(match_defer_i), .wait_trig_i(wait_trig_i),
        .chain_trig_i(chain_trig_i), .tmo_irq_mask_i(tmo_irq_mask_i),
        .match_irq_en_i(match_irq_en_i), .count_o(count_o), .cmp_o(cmp_o),
        .tmo_irq_o(tmo_irq_o), .match_irq_o(match_irq_o), .tmo_trig_o(tmo_trig_o)
    );

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] val;
        string       req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;
    logic  exp_cmp = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            SEL_CNT:  return count_o;
            SEL_CMP:  return {31'd0, cmp_o};
            SEL_TIRQ: return {31'd0, tmo_irq_o};
            SEL_MIRQ: return {31'd0, match_irq_o};
            default:  return {31'd0, tmo_trig_o};
        endcase
    endfunction

    function automatic string sel_name(int sel);
        case (sel)
            SEL_CNT:  return "count_o";
            SEL_CMP:  return "cmp_o";
            SEL_TIRQ: return "tmo_irq_o";
            SEL_MIRQ: return "match_irq_o";
            default:  return "tmo_trig_o";
        endcase
    endfunction

    task automatic check_now(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Monitor: compare every queued item that falls due in this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                check_now(q[i].req, sel_name(q[i].sel), observe(q[i].sel), q[i].val);
                q.delete(i);
            end
        end
    end

    task automatic expect_at(int c, int sel, logic [31:0] v, string req);
        item_t it;
        it.cyc = c; it.sel = sel; it.val = v; it.req = req;
        q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_load(logic [31:0] v);
        load_val_i = v; load_wr_i = 1'b1; step(1); load_wr_i = 1'b0;
    endtask

    task automatic write_match(logic [31:0] v);
        match_val_i = v; match_wr_i = 1'b1; step(1); match_wr_i = 1'b0;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        int c;
        step(3);
        // R11: reset state
        check_now("R11", "count_o", count_o, 0);
        check_now("R11", "cmp_o", {31'd0, cmp_o}, 0);
        check_now("R11", "pulses", {29'd0, tmo_irq_o, match_irq_o, tmo_trig_o}, 0);
        rst_n = 1'b1;
        step(2);

        // Periodic down, action 4, match at 2
        mode_i = 2'd2; count_up_i = 0; cmp_act_i = 3'd4; match_irq_en_i = 1;
        write_load(5); write_match(2);
        enable_i = 1; c = cyc;
        expect_at(c+1,  SEL_CNT, 5, "R2");
        expect_at(c+1,  SEL_CMP, 1, "R3");
        expect_at(c+4,  SEL_CNT, 2, "R2");
        expect_at(c+5,  SEL_MIRQ, 1, "R9");
        expect_at(c+6,  SEL_MIRQ, 0, "R9");
        expect_at(c+6,  SEL_TRIG, 0, "R2");
        expect_at(c+7,  SEL_TRIG, 1, "R2");
        expect_at(c+7,  SEL_TIRQ, 1, "R10");
        expect_at(c+7,  SEL_CNT, 5, "R1");
        expect_at(c+7,  SEL_CMP, 0, "R4");
        expect_at(c+8,  SEL_TRIG, 0, "R10");
        expect_at(c+11, SEL_MIRQ, 1, "R9");
        expect_at(c+13, SEL_CMP, 1, "R4");
        expect_at(c+18, SEL_CNT, 4, "R1");
        step(14); enable_i = 0; step(6);
        exp_cmp = 1'b1;

        // One-shot up, action 7, timeout interrupt masked, match disabled
        mode_i = 2'd1; count_up_i = 1; cmp_act_i = 3'd7;
        tmo_irq_mask_i = 1; match_irq_en_i = 0;
        write_load(3); write_match(1);
        enable_i = 1; c = cyc;
        expect_at(c+1, SEL_CNT, 0, "R2");
        expect_at(c+1, SEL_CMP, 0, "R3");
        expect_at(c+3, SEL_MIRQ, 0, "R9");
        expect_at(c+4, SEL_CNT, 3, "R2");
        expect_at(c+5, SEL_TRIG, 1, "R10");
        expect_at(c+5, SEL_TIRQ, 0, "R10");
        expect_at(c+5, SEL_CMP, 1, "R4");
        expect_at(c+9, SEL_CNT, 3, "R1");
        expect_at(c+9, SEL_TRIG, 0, "R1");
        step(10); enable_i = 0; tmo_irq_mask_i = 0; step(2);

        // Reserved mode does not count
        mode_i = 2'd0; cmp_act_i = 3'd0;
        enable_i = 1; c = cyc;
        expect_at(c+3,  SEL_CNT, 3, "R1");
        expect_at(c+10, SEL_CNT, 3, "R1");
        expect_at(c+10, SEL_TRIG, 0, "R1");
        step(11); enable_i = 0; step(2);

        // Immediate load while running down
        mode_i = 2'd2; count_up_i = 0; load_defer_i = 0;
        write_load(4);
        enable_i = 1; c = cyc;
        step(2); write_load(10);
        expect_at(c+3,  SEL_CNT, 10, "R5");
        expect_at(c+4,  SEL_CNT, 9, "R5");
        expect_at(c+14, SEL_TRIG, 1, "R5");
        expect_at(c+14, SEL_CNT, 10, "R5");
        step(13); enable_i = 0; step(2);

        // Deferred load while running down (start applies pending 4: R7)
        load_defer_i = 1;
        write_load(4);
        enable_i = 1; c = cyc;
        expect_at(c+1, SEL_CNT, 4, "R7");
        step(2); write_load(10);
        expect_at(c+3, SEL_CNT, 2, "R5");
        expect_at(c+6, SEL_TRIG, 1, "R5");
        expect_at(c+6, SEL_CNT, 10, "R5");
        expect_at(c+7, SEL_CNT, 9, "R5");
        step(6); enable_i = 0; step(2);

        // Counting up ignores the load defer bit
        count_up_i = 1;
        write_load(6);
        enable_i = 1; c = cyc;
        step(1); write_load(3);
        expect_at(c+4, SEL_CNT, 3, "R5");
        expect_at(c+5, SEL_TRIG, 1, "R5");
        expect_at(c+5, SEL_CNT, 0, "R2");
        expect_at(c+8, SEL_TRIG, 0, "R5");
        expect_at(c+9, SEL_TRIG, 1, "R5");
        step(9); enable_i = 0; load_defer_i = 0; step(2);

        // Deferred match update
        count_up_i = 0; match_defer_i = 1; match_irq_en_i = 1;
        write_load(6); write_match(1);
        enable_i = 1; c = cyc;
        step(1); write_match(4);
        expect_at(c+4,  SEL_MIRQ, 0, "R6");
        expect_at(c+7,  SEL_MIRQ, 1, "R6");
        expect_at(c+8,  SEL_TRIG, 1, "R6");
        expect_at(c+11, SEL_MIRQ, 1, "R6");
        expect_at(c+14, SEL_MIRQ, 0, "R6");
        step(14); enable_i = 0; match_defer_i = 0; match_irq_en_i = 0; step(2);

        // Wait on chain trigger, pending load applied at start
        mode_i = 2'd1; load_defer_i = 1; wait_trig_i = 1;
        write_load(3);
        enable_i = 1; c = cyc;
        expect_at(c+1,  SEL_CNT, 3, "R7");
        expect_at(c+5,  SEL_CNT, 3, "R8");
        step(5);
        chain_trig_i = 1; step(1); chain_trig_i = 0;
        expect_at(c+7,  SEL_CNT, 2, "R8");
        expect_at(c+10, SEL_TRIG, 1, "R8");
        step(5); enable_i = 0; wait_trig_i = 0; load_defer_i = 0; step(2);

        // Every action code on a one-shot down run of load 2
        write_load(2);
        for (int a = 0; a < 8; a++) begin
            logic s, t;
            s = (a == 4 || a == 6) ? 1'b1 : (a == 5 || a == 7) ? 1'b0 : exp_cmp;
            t = (a == 1 || a == 4 || a == 5) ? ~s :
                (a == 2 || a == 6) ? 1'b0 :
                (a == 3 || a == 7) ? 1'b1 : s;
            cmp_act_i = 3'(a);
            enable_i = 1; c = cyc;
            expect_at(c+1, SEL_CMP, {31'd0, s}, "R3");
            expect_at(c+4, SEL_CMP, {31'd0, t}, "R4");
            step(5); enable_i = 0; step(2);
            exp_cmp = t;
        end

        wait (q.size() == 0);
        step(2);
        report();
    end

endmodule